// File: doc/BRIEF.md
# Programmable CPU Address Window Decoder

This block holds a bank of programmable decode windows that steer each CPU bus address to a destination unit. Every window carries a control word (size mask, attribute byte, 4-bit destination ID and an enable bit) and a 64 KB aligned base. The lowest-numbered windows also carry a translation base, so that a CPU address can be moved to a different place in the destination's own address space.

Software programs the windows through a simple 32-bit register write/read port. The write takes effect on the next rising clock edge, and the read data is combinational. A separate combinational lookup port accepts an address. It returns whether any window claims it, together with the destination ID, the attribute, the index of the claiming window and the translated address. If several windows overlap, the lowest index takes the address.

Top module: `cpu_win_map`

## Requirements
- R1: The register byte offset is formed as window index × 16 plus a register select. Select 0x0 is control, 0x4 is base, 0x8 is translation-low and 0xC is translation-high. Port `cfg_addr` carries byte-offset bits [log2(NUM_WIN)+3:2].
- R2: The control word keeps bits 31:16 (size − 1 in 64 KB units), 15:8 (attribute), 7:4 (destination ID) and bit 0 (enable). Bits 3:1 read back as zero.
- R3: The base register keeps bits 31:16 only. Writes to bits 15:0 are dropped, and those bits read as zero.
- R4: Only windows with an index below REMAP_WINS have translation registers. For every other window both translation registers read as zero, and writes to them have no effect on the lookup.
- R5: Translation-low keeps bits 31:16, and bits 15:0 read as zero. Translation-high keeps all 32 bits, reads back as written and does not enter the 32-bit lookup.
- R6: After reset every register reads zero and no address hits.
- R7: A window hits when its enable is 1 and (addr[31:16] & ~size) equals (base[31:16] & ~size), with size taken from control bits 31:16.
- R8: When several windows hit, `lk_win` reports the lowest-numbered one, and its fields drive the outputs.
- R9: On a miss, `lk_hit`, `lk_target`, `lk_attr` and `lk_win` are 0, and `lk_xaddr` equals `lk_addr`.
- R10: On a hit, `lk_target` and `lk_attr` equal control bits 7:4 and 15:8 of the winning window. Conventional destination codes are DRAM = 0, device bus = 1, PCI = 3 and PCIe = 4.
- R11: On a hit by a window with translation, `lk_xaddr[31:16]` = (xlo[31:16] & ~size) | (addr[31:16] & size) and `lk_xaddr[15:0]` = `addr[15:0]`. A hit by a window without translation passes the address through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | log2(NUM_WIN)+2 | Register byte offset, bits [log2(NUM_WIN)+3:2] |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| lk_addr | input | 32 | Address to decode |
| lk_hit | output | 1 | A window claims the address |
| lk_target | output | 4 | Destination ID of the winning window |
| lk_attr | output | 8 | Attribute of the winning window |
| lk_win | output | log2(NUM_WIN) | Index of the winning window |
| lk_xaddr | output | 32 | Translated address |

## Verification
The bench builds the decoder with NUM_WIN = 8 and REMAP_WINS = 2. With this setting both translating windows and windows without translation appear in one configuration, so the zero read-back and the pass-through case are exercised next to the translating case. Because the upper address half is only 16 bits wide, every one of its 65536 values is swept through the lookup in two window layouts. These layouts include overlapping windows, a disabled window, a single-64 KB window and a translation register written on a window that has none. Every register of all eight windows is also written with a distinct pattern and read back.

// File: rtl/cpu_win_pkg.sv
package cpu_win_pkg;

  // register select inside one window's 16-byte slot
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_BASE = 2'd1;
  localparam logic [1:0] SEL_XLO  = 2'd2;
  localparam logic [1:0] SEL_XHI  = 2'd3;

  // conventional destination codes
  localparam logic [3:0] DEST_DRAM = 4'd0;
  localparam logic [3:0] DEST_DEVB = 4'd1;
  localparam logic [3:0] DEST_PCI  = 4'd3;
  localparam logic [3:0] DEST_PCIE = 4'd4;

  typedef struct packed {
    logic [15:0] size_m1;
    logic [7:0]  attr;
    logic [3:0]  dest;
    logic        en;
  } win_ctrl_t;

  function automatic logic [31:0] ctrl_to_word(win_ctrl_t c);
    return {c.size_m1, c.attr, c.dest, 3'b000, c.en};
  endfunction

endpackage

// File: rtl/cpu_win_regs.sv
module cpu_win_regs
  import cpu_win_pkg::*;
#(
  parameter int NUM_WIN    = 8,
  parameter int REMAP_WINS = 4,
  localparam int IW        = $clog2(NUM_WIN)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IW-1:0]               acc_win,
  input  logic [1:0]                  acc_sel,
  input  logic [31:0]                 wr_data,
  output logic [31:0]                 rd_data,
  output win_ctrl_t [NUM_WIN-1:0]     ctrl_o,
  output logic [NUM_WIN-1:0][15:0]    base_o,
  output logic [NUM_WIN-1:0][15:0]    xlo_o
);

  logic [NUM_WIN-1:0][31:0] xhi_w;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    win_ctrl_t   ctrl_q, ctrl_d;
    logic [15:0] base_q, base_d;
    logic        hit_slot;

    assign hit_slot = wr_en && (acc_win == IW'(w));

    always_comb begin
      ctrl_d = ctrl_q;
      base_d = base_q;
      if (hit_slot && acc_sel == SEL_CTRL) begin
        ctrl_d.size_m1 = wr_data[31:16];
        ctrl_d.attr    = wr_data[15:8];
        ctrl_d.dest    = wr_data[7:4];
        ctrl_d.en      = wr_data[0];
      end
      if (hit_slot && acc_sel == SEL_BASE) base_d = wr_data[31:16];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q <= '0;
        base_q <= '0;
      end else begin
        ctrl_q <= ctrl_d;
        base_q <= base_d;
      end
    end

    assign ctrl_o[w] = ctrl_q;
    assign base_o[w] = base_q;

    if (w < REMAP_WINS) begin : g_xlate
      logic [15:0] xlo_q, xlo_d;
      logic [31:0] xhi_q, xhi_d;

      always_comb begin
        xlo_d = xlo_q;
        xhi_d = xhi_q;
        if (hit_slot && acc_sel == SEL_XLO) xlo_d = wr_data[31:16];
        if (hit_slot && acc_sel == SEL_XHI) xhi_d = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          xlo_q <= '0;
          xhi_q <= '0;
        end else begin
          xlo_q <= xlo_d;
          xhi_q <= xhi_d;
        end
      end

      assign xlo_o[w] = xlo_q;
      assign xhi_w[w] = xhi_q;
    end else begin : g_plain
      assign xlo_o[w] = '0;
      assign xhi_w[w] = '0;
    end
  end

  always_comb begin
    unique case (acc_sel)
      SEL_CTRL: rd_data = ctrl_to_word(ctrl_o[acc_win]);
      SEL_BASE: rd_data = {base_o[acc_win], 16'h0000};
      SEL_XLO:  rd_data = {xlo_o[acc_win], 16'h0000};
      default:  rd_data = xhi_w[acc_win];
    endcase
  end

endmodule

// File: rtl/cpu_win_match.sv
module cpu_win_match (
  input  logic        en,
  input  logic [15:0] size_m1,
  input  logic [15:0] base_hi,
  input  logic [15:0] addr_hi,
  output logic        hit
);

  logic [15:0] keep_mask;

  assign keep_mask = ~size_m1;
  assign hit       = en && ((addr_hi & keep_mask) == (base_hi & keep_mask));

endmodule

// File: rtl/cpu_win_pick.sv
module cpu_win_pick #(
  parameter int NUM_WIN = 8,
  localparam int IW     = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0] hits,
  output logic               found,
  output logic [IW-1:0]      idx
);

  // scan from the top so the lowest set index is written last
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hits[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/cpu_win_map.sv
module cpu_win_map
  import cpu_win_pkg::*;
#(
  parameter int NUM_WIN    = 8,
  parameter int REMAP_WINS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [$clog2(NUM_WIN)+3:2]   cfg_addr,
  input  logic [31:0]                  cfg_wdata,
  output logic [31:0]                  cfg_rdata,
  input  logic [31:0]                  lk_addr,
  output logic                         lk_hit,
  output logic [3:0]                   lk_target,
  output logic [7:0]                   lk_attr,
  output logic [$clog2(NUM_WIN)-1:0]   lk_win,
  output logic [31:0]                  lk_xaddr
);

  localparam int IW = $clog2(NUM_WIN);

  win_ctrl_t [NUM_WIN-1:0]     ctrl;
  logic [NUM_WIN-1:0][15:0]    base;
  logic [NUM_WIN-1:0][15:0]    xlo;
  logic [NUM_WIN-1:0]          hits;
  logic [NUM_WIN-1:0]          can_xlate;
  logic                        found;
  logic [IW-1:0]               pick;
  win_ctrl_t                   sel_ctrl;
  logic [15:0]                 sel_xlo;

  cpu_win_regs #(
    .NUM_WIN    (NUM_WIN),
    .REMAP_WINS (REMAP_WINS)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .acc_win (cfg_addr[IW+3:4]),
    .acc_sel (cfg_addr[3:2]),
    .wr_data (cfg_wdata),
    .rd_data (cfg_rdata),
    .ctrl_o  (ctrl),
    .base_o  (base),
    .xlo_o   (xlo)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    assign can_xlate[w] = (w < REMAP_WINS);
    cpu_win_match u_match (
      .en      (ctrl[w].en),
      .size_m1 (ctrl[w].size_m1),
      .base_hi (base[w]),
      .addr_hi (lk_addr[31:16]),
      .hit     (hits[w])
    );
  end

  cpu_win_pick #(.NUM_WIN(NUM_WIN)) u_pick (
    .hits  (hits),
    .found (found),
    .idx   (pick)
  );

  assign sel_ctrl = ctrl[pick];
  assign sel_xlo  = xlo[pick];

  always_comb begin
    lk_hit    = found;
    lk_target = '0;
    lk_attr   = '0;
    lk_win    = '0;
    lk_xaddr  = lk_addr;
    if (found) begin
      lk_target = sel_ctrl.dest;
      lk_attr   = sel_ctrl.attr;
      lk_win    = pick;
      if (can_xlate[pick]) begin
        lk_xaddr[31:16] = (sel_xlo & ~sel_ctrl.size_m1) |
                          (lk_addr[31:16] & sel_ctrl.size_m1);
      end
    end
  end

endmodule

// File: rtl/cpu_win_map_chk.sv
module cpu_win_map_chk #(
  parameter int NUM_WIN    = 8,
  parameter int REMAP_WINS = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cfg_we,
  input logic [$clog2(NUM_WIN)+3:2]  cfg_addr,
  input logic [31:0]                 cfg_wdata,
  input logic [31:0]                 cfg_rdata,
  input logic [31:0]                 lk_addr,
  input logic                        lk_hit,
  input logic [3:0]                  lk_target,
  input logic [7:0]                  lk_attr,
  input logic [$clog2(NUM_WIN)-1:0]  lk_win,
  input logic [31:0]                 lk_xaddr
);

  localparam int IW = $clog2(NUM_WIN);

  logic acc_plain;
  logic win_plain;
  assign acc_plain = (int'(cfg_addr[IW+3:4]) >= REMAP_WINS);
  assign win_plain = (int'(lk_win) >= REMAP_WINS);

  // R2
  ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && $past(cfg_addr[3:2]) == 2'd0 && cfg_addr == $past(cfg_addr))
    |-> cfg_rdata == ($past(cfg_wdata) & 32'hFFFF_FFF1));

  // R3
  base_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && $past(cfg_addr[3:2]) == 2'd1 && cfg_addr == $past(cfg_addr))
    |-> cfg_rdata == {$past(cfg_wdata[31:16]), 16'h0000});

  // R4
  no_xlate_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[3] && acc_plain) |-> cfg_rdata == 32'h0);

  // R6
  reset_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !lk_hit);

  // R9
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_target == 4'h0 && lk_attr == 8'h00 && lk_win == '0 && lk_xaddr == lk_addr));

  // R11
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_xaddr[15:0] == lk_addr[15:0]);

  // R11
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && win_plain) |-> lk_xaddr == lk_addr);

endmodule

bind cpu_win_map cpu_win_map_chk #(
  .NUM_WIN    (NUM_WIN),
  .REMAP_WINS (REMAP_WINS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .lk_addr   (lk_addr),
  .lk_hit    (lk_hit),
  .lk_target (lk_target),
  .lk_attr   (lk_attr),
  .lk_win    (lk_win),
  .lk_xaddr  (lk_xaddr)
);

// File: tb/sim_cpu_win_map.sv
module sim_cpu_win_map;

  localparam int NW = 8;
  localparam int RW = 2;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [6:2]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [31:0] lk_addr;
  logic        lk_hit;
  logic [3:0]  lk_target;
  logic [7:0]  lk_attr;
  logic [2:0]  lk_win;
  logic [31:0] lk_xaddr;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  // model of what was written (raw words)
  logic [31:0] m_reg [NW][4];

  cpu_win_map #(.NUM_WIN(NW), .REMAP_WINS(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_target(lk_target), .lk_attr(lk_attr),
    .lk_win(lk_win), .lk_xaddr(lk_xaddr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] exp_read(int w, int s);
    logic [31:0] v = m_reg[w][s];
    case (s)
      0: return v & 32'hFFFF_FFF1;
      1: return v & 32'hFFFF_0000;
      2: return (w < RW) ? (v & 32'hFFFF_0000) : 32'h0;
      default: return (w < RW) ? v : 32'h0;
    endcase
  endfunction

  task automatic wr(int w, int s, logic [31:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = {w[2:0], s[1:0]};
    cfg_wdata = d;
    m_reg[w][s] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(int w, int s, string tag);
    logic [31:0] e;
    @(negedge clk);
    cfg_addr = {w[2:0], s[1:0]};
    #1;
    e = exp_read(w, s);
    checks++;
    if (cfg_rdata !== e) begin
      errs++;
      $display("FAIL %s win%0d sel%0d: got %08h expected %08h", tag, w, s, cfg_rdata, e);
    end
  endtask

  task automatic clear_all();
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < 4; s++) wr(w, s, 32'h0);
  endtask

  task automatic look_chk(logic [31:0] a);
    logic        eh;
    logic [3:0]  et;
    logic [7:0]  ea;
    logic [2:0]  ew;
    logic [31:0] ex;
    eh = 0; et = 0; ea = 0; ew = 0; ex = a;
    for (int w = NW - 1; w >= 0; w--) begin
      logic [15:0] sz;
      logic [15:0] bs;
      sz = m_reg[w][0][31:16];
      bs = m_reg[w][1][31:16];
      if (m_reg[w][0][0] && ((a[31:16] & ~sz) == (bs & ~sz))) begin
        eh = 1;
        et = m_reg[w][0][7:4];
        ea = m_reg[w][0][15:8];
        ew = w[2:0];
        ex = a;
        if (w < RW) ex[31:16] = (m_reg[w][2][31:16] & ~sz) | (a[31:16] & sz);
      end
    end
    lk_addr = a;
    #1;
    checks++;
    if (lk_hit !== eh) begin
      errs++;
      $display("FAIL R7 addr %08h: hit got %0b expected %0b", a, lk_hit, eh);
    end else if (!eh && (lk_target !== 0 || lk_attr !== 0 || lk_win !== 0 || lk_xaddr !== a)) begin
      errs++;
      $display("FAIL R9 addr %08h: got t=%0h a=%0h w=%0d x=%08h expected zeros x=%08h",
               a, lk_target, lk_attr, lk_win, lk_xaddr, a);
    end else if (eh && lk_win !== ew) begin
      errs++;
      $display("FAIL R8 addr %08h: win got %0d expected %0d", a, lk_win, ew);
    end else if (eh && (lk_target !== et || lk_attr !== ea)) begin
      errs++;
      $display("FAIL R10 addr %08h: t/a got %0h/%0h expected %0h/%0h", a, lk_target, lk_attr, et, ea);
    end else if (lk_xaddr !== ex) begin
      errs++;
      $display("FAIL R11 addr %08h: xaddr got %08h expected %08h", a, lk_xaddr, ex);
    end
  endtask

  task automatic sweep();
    for (int h = 0; h < 65536; h++) begin
      logic [15:0] lo;
      lo = 16'(h * 16'h9E37) ^ 16'h5A5A;
      look_chk({h[15:0], lo});
    end
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < 4; s++) m_reg[w][s] = 32'h0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; lk_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6: reset state
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < 4; s++) rd_chk(w, s, "R6");
    look_chk(32'h0000_0000);
    look_chk(32'h1234_5678);
    look_chk(32'hFFFF_FFFF);

    // R1 R2 R3 R4 R5: distinct pattern per register, then read everything back
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < 4; s++)
        wr(w, s, 32'hA5C3_0F6E ^ (32'(w) * 32'h0101_0137) ^ (32'(s) << 28) ^ 32'h0000_000F);
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < 4; s++) rd_chk(w, s, "R1/R2/R3/R4/R5");

    // layout A: overlaps, disabled window, untranslated window with xlo written
    clear_all();
    wr(0, 1, 32'h1000_FFFF); wr(0, 2, 32'h8000_1234); wr(0, 3, 32'h0);
    wr(0, 0, 32'h0FFF_0E0F);              // 256 MB, attr 0E, DRAM, enable
    wr(1, 1, 32'h1800_0000); wr(1, 2, 32'h2300_0000);
    wr(1, 0, 32'h00FF_5131);              // overlaps window 0, PCI
    wr(2, 1, 32'h2000_0000); wr(2, 2, 32'hDEAD_0000);
    wr(2, 0, 32'h003F_5941);              // PCIe, no translation hardware
    wr(3, 1, 32'h3000_0000); wr(3, 0, 32'h0FFF_0F10); // disabled
    wr(5, 1, 32'h3000_0000); wr(5, 0, 32'h0000_1E11); // 64 KB device bus
    wr(7, 1, 32'h3000_0000); wr(7, 0, 32'h00FF_1D11);
    rd_chk(2, 2, "R4");
    sweep();

    // layout B: window 0 off, window 1 now visible with translation
    wr(0, 0, 32'h0FFF_0E0E);
    wr(6, 1, 32'hF000_0000); wr(6, 0, 32'h0FFF_5131);
    sweep();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule